// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised set of external interrupt lines and turns them into one interrupt output per processor. Each line is sampled through a two-stage synchroniser and then treated as a level source, a single-edge source, or a dual-edge source. Edge sources are held in a latch until software acknowledges them. A line is presented to a processor when it is pending, its enable bit is set, and its route register names that processor.

Software reaches all state through a single-cycle register port with 32-bit words. Enables are changed only through write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. A wedge word lets software raise or acknowledge any edge source, which serves for inter-processor signalling. For each processor a read-only word returns the lowest-numbered source that is currently presented to it.

Top module: `shint_ctrl`

## Requirements
- R1: After reset, every source has positive polarity, level trigger, dual-edge off, enable clear and a route to processor 0. Every `cpu_irq` bit is 0 and every lowest-source word reads NUM_SRC.
- R2: The word at byte 0x000 is read-only. Bits [23:16] hold NUM_SRC/8-1, bits [7:0] hold NUM_CPU-1, and all other bits read 0.
- R3: A level source (trigger bit 0) is pending while its synchronised input equals its polarity bit (1 = high, 0 = low). Nothing is latched. A change on the input shows in the pending word two clock edges after it is driven.
- R4: An edge source (trigger bit 1, dual bit 0) latches pending on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The latch holds after the input returns. The latch is visible three clock edges after the input change.
- R5: With the dual bit set, an edge source latches on both rising and falling edges, and its polarity bit has no effect.
- R6: Writing word 0x140+4w sets enable bits, and writing 0x180+4w clears them, for every 1 in the data. A 0 data bit leaves the enable unchanged. The enable state reads at 0x100+4w.
- R7: A write to byte 0x004 with bit 31 = 1 latches the source numbered in bits [15:0] as pending. With bit 31 = 0 it clears that latch. A level source is unaffected by either kind of write, and a source number of NUM_SRC or above is ignored.
- R8: The word at 0x400+4s holds the processor index for source s. A write with a value of NUM_CPU or above is ignored. A source is presented to its routed processor only, so moving it removes it from the previous one.
- R9: `cpu_irq[c]` is 1 exactly when some source is pending, enabled and routed to processor c. Clearing an enable leaves the pending state unchanged.
- R10: The word at 0x800+4c returns the lowest source number that is pending, enabled and routed to processor c, or NUM_SRC when there is none.
- R11: Polarity (0x040), trigger (0x080), dual (0x0C0), enable and pending (0x1C0) are word arrays. Source s sits at bit s%32 of the word at base+4*(s/32). Unimplemented bits read 0, and accesses with byte address bits [1:0] nonzero are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Asynchronous interrupt lines |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| cpu_irq | output | NUM_CPU | Per-processor interrupt request |

## Verification
The bench builds the controller with 40 sources and 3 processors. With 40 sources the second register word is only partly implemented, so the bench can check that unused bits read 0, that the configuration field encodes a non-trivial source count, and that the "none pending" code (40) is not a power of two. Three processors leave route index 3 unused, so an out-of-range route write can be tried. They also allow a source to move between two non-zero processors while a third is observed.

// File: rtl/shint_pkg.sv
package shint_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_WEDGE,
        ACC_POL,
        ACC_TRIG,
        ACC_DUAL,
        ACC_MASK,
        ACC_SETM,
        ACC_CLRM,
        ACC_PEND,
        ACC_ROUTE,
        ACC_LOW
    } acc_e;

    localparam int WEDGE_SET_BIT = 31;

    function automatic acc_e decode_acc(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00)        return ACC_NONE;
        if (a == 12'h000)           return ACC_CFG;
        if (a == 12'h004)           return ACC_WEDGE;
        if (a[11:10] == 2'b01)      return ACC_ROUTE;
        if (a[11:8] == 4'h8)        return ACC_LOW;
        case (a[11:6])
            6'd1:    return ACC_POL;
            6'd2:    return ACC_TRIG;
            6'd3:    return ACC_DUAL;
            6'd4:    return ACC_MASK;
            6'd5:    return ACC_SETM;
            6'd6:    return ACC_CLRM;
            6'd7:    return ACC_PEND;
            default: return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/shint_sync.sv
module shint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/shint_pend.sv
module shint_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] dual,
    input  logic [N-1:0] wset,
    input  logic [N-1:0] wclr,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] hold;
    } pst_t;

    pst_t st_d, st_q;
    logic [N-1:0] rise, fall, hit;

    always_comb begin
        rise = lvl_in & ~st_q.prev;
        fall = ~lvl_in & st_q.prev;
        hit  = (dual & (rise | fall))
             | (~dual & pol & rise)
             | (~dual & ~pol & fall);
        st_d.prev = lvl_in;
        // a new edge or a wedge set wins over a same-cycle acknowledge
        st_d.hold = trig & ((st_q.hold & ~wclr) | hit | wset);
        pend = (trig & st_q.hold) | (~trig & (pol ~^ lvl_in));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/shint_pick.sv
module shint_pick #(
    parameter int N  = 8,
    parameter int C  = 2,
    parameter int CW = 1,
    parameter int IW = 4
) (
    input  logic [N-1:0]         pend,
    input  logic [N-1:0]         mask,
    input  logic [N-1:0][CW-1:0] route,
    output logic [C-1:0]         irq,
    output logic [C-1:0][IW-1:0] low
);
    for (genvar c = 0; c < C; c++) begin : g_cpu
        logic [N-1:0]  cand;
        logic [IW-1:0] first;
        always_comb begin
            for (int i = 0; i < N; i++) begin
                cand[i] = pend[i] & mask[i] & (route[i] == CW'(c));
            end
            first = IW'(N);
            for (int i = N - 1; i >= 0; i--) begin
                if (cand[i]) first = IW'(i);
            end
        end
        assign irq[c] = |cand;
        assign low[c] = first;
    end
endmodule

// File: rtl/shint_ctrl.sv
module shint_ctrl
    import shint_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int IW = $clog2(NUM_SRC + 1);

    typedef struct packed {
        logic [NUM_SRC-1:0]         pol;
        logic [NUM_SRC-1:0]         trig;
        logic [NUM_SRC-1:0]         dual;
        logic [NUM_SRC-1:0]         mask;
        logic [NUM_SRC-1:0][CW-1:0] route;
    } cfg_t;

    cfg_t st_d, st_q;

    logic [NUM_SRC-1:0]         lvl_sync;
    logic [NUM_SRC-1:0]         wset, wclr;
    logic [NUM_SRC-1:0]         pend_cur, mask_cur, trig_cur;
    logic [NUM_CPU-1:0][IW-1:0] low_idx;
    acc_e                       acc;
    logic                       wr_go;
    logic                       route_ok;
    int                         widx, ridx, cidx;

    shint_sync #(.W(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_in),
        .sync_out (lvl_sync)
    );

    shint_pend #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (lvl_sync),
        .pol    (st_q.pol),
        .trig   (st_q.trig),
        .dual   (st_q.dual),
        .wset   (wset),
        .wclr   (wclr),
        .pend   (pend_cur)
    );

    shint_pick #(.N(NUM_SRC), .C(NUM_CPU), .CW(CW), .IW(IW)) u_pick (
        .pend  (pend_cur),
        .mask  (st_q.mask),
        .route (st_q.route),
        .irq   (cpu_irq),
        .low   (low_idx)
    );

    assign mask_cur = st_q.mask;
    assign trig_cur = st_q.trig;

    always_comb begin
        acc      = decode_acc(bus_addr);
        wr_go    = bus_en & bus_wr;
        widx     = int'(bus_addr[5:2]);
        ridx     = int'(bus_addr[9:2]);
        cidx     = int'(bus_addr[7:2]);
        route_ok = bus_wdata < 32'(NUM_CPU);
        st_d     = st_q;

        // wedge decode, one compare per source keeps the index in range
        for (int i = 0; i < NUM_SRC; i++) begin
            wset[i] = wr_go && (acc == ACC_WEDGE) && bus_wdata[WEDGE_SET_BIT]
                      && (bus_wdata[15:0] == 16'(i));
            wclr[i] = wr_go && (acc == ACC_WEDGE) && !bus_wdata[WEDGE_SET_BIT]
                      && (bus_wdata[15:0] == 16'(i));
        end

        // word-array writes
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_go && ((i / 32) == widx)) begin
                case (acc)
                    ACC_POL:  st_d.pol[i]  = bus_wdata[i % 32];
                    ACC_TRIG: st_d.trig[i] = bus_wdata[i % 32];
                    ACC_DUAL: st_d.dual[i] = bus_wdata[i % 32];
                    ACC_SETM: if (bus_wdata[i % 32]) st_d.mask[i] = 1'b1;
                    ACC_CLRM: if (bus_wdata[i % 32]) st_d.mask[i] = 1'b0;
                    default: ;
                endcase
            end
            if (wr_go && (acc == ACC_ROUTE) && (i == ridx) && route_ok) begin
                st_d.route[i] = bus_wdata[CW-1:0];
            end
        end

        // read mux
        bus_rdata = '0;
        if (bus_en && !bus_wr) begin
            case (acc)
                ACC_CFG: begin
                    bus_rdata[23:16] = 8'(NUM_SRC / 8 - 1);
                    bus_rdata[7:0]   = 8'(NUM_CPU - 1);
                end
                ACC_POL, ACC_TRIG, ACC_DUAL, ACC_MASK, ACC_PEND: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        if ((i / 32) == widx) begin
                            case (acc)
                                ACC_POL:  bus_rdata[i % 32] = st_q.pol[i];
                                ACC_TRIG: bus_rdata[i % 32] = st_q.trig[i];
                                ACC_DUAL: bus_rdata[i % 32] = st_q.dual[i];
                                ACC_MASK: bus_rdata[i % 32] = st_q.mask[i];
                                default:  bus_rdata[i % 32] = pend_cur[i];
                            endcase
                        end
                    end
                end
                ACC_ROUTE: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        if (i == ridx) bus_rdata = 32'(st_q.route[i]);
                    end
                end
                ACC_LOW: begin
                    for (int c = 0; c < NUM_CPU; c++) begin
                        if (c == cidx) bus_rdata = 32'(low_idx[c]);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pol   <= '1;
            st_q.trig  <= '0;
            st_q.dual  <= '0;
            st_q.mask  <= '0;
            st_q.route <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/shint_ctrl_chk.sv
module shint_ctrl_chk #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_wr,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NUM_CPU-1:0] cpu_irq,
    input logic [NUM_SRC-1:0] mask_v,
    input logic [NUM_SRC-1:0] trig_v,
    input logic [NUM_SRC-1:0] pend_v
);
    localparam int NW  = (NUM_SRC + 31) / 32;
    localparam int IXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [NW*32-1:0] IMPL = {(NW*32){1'b1}} >> (NW*32 - NUM_SRC);

    logic [NW*32-1:0] mpad;
    logic             wr_go;
    assign mpad  = (NW*32)'(mask_v);
    assign wr_go = bus_en && bus_wr;

    // R1: no request while reset holds the enables clear
    always @(posedge clk) begin
        if (!rst_n) begin
            p_irq_quiet_reset_r1: assert (cpu_irq == '0);
        end
    end

    // R6: set-enable word 0 turns on every written 1 that exists
    p_setmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && bus_addr == 12'h140)
        |=> ((mpad[31:0] & $past(bus_wdata)) == ($past(bus_wdata) & IMPL[31:0])));

    // R6: clear-enable word 0 turns off every written 1
    p_clrmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && bus_addr == 12'h180)
        |=> ((mpad[31:0] & $past(bus_wdata)) == 32'h0));

    // R7: wedge set on an edge source leaves it pending
    p_wedge_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && bus_addr == 12'h004 && bus_wdata[31]
         && bus_wdata[15:0] < 16'(NUM_SRC) && trig_v[bus_wdata[IXW-1:0]])
        |=> pend_v[$past(bus_wdata[IXW-1:0])]);

    // R9: any request needs at least one enabled source
    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> (mask_v != '0));
endmodule

bind shint_ctrl shint_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cpu_irq   (cpu_irq),
    .mask_v    (mask_cur),
    .trig_v    (trig_cur),
    .pend_v    (pend_cur)
);

// File: tb/sim_shint_ctrl.sv
module sim_shint_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 40;
    localparam int NC = 3;
    localparam int TS = 33;

    typedef struct packed {
        logic       trig;
        logic       dual;
        logic       pol;
        logic       init;
        logic [3:0] seq;
        logic [3:0] exp;
    } vec_t;

    // bit k of seq/exp belongs to step k
    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'b1101, 4'b1101},  // R3 level high
        '{1'b0, 1'b0, 1'b0, 1'b0, 4'b1001, 4'b0110},  // R3 level low
        '{1'b1, 1'b0, 1'b1, 1'b0, 4'b1001, 4'b1111},  // R4 rising
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'b1001, 4'b1110},  // R4 falling
        '{1'b1, 1'b1, 1'b1, 1'b1, 4'b0001, 4'b1110},  // R5 dual, fall with pol=1
        '{1'b1, 1'b0, 1'b1, 1'b1, 4'b0011, 4'b0000},  // R4 falls ignored
        '{1'b1, 1'b1, 1'b0, 1'b0, 4'b0010, 4'b1110}   // R5 dual, rise with pol=0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic          bus_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] cpu_irq;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shint_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        check("R1 irq in reset", 32'(cpu_irq), 32'h0);
        rst_n = 1'b1;
        idle(2);

        // reset state
        check("R1 irq", 32'(cpu_irq), 32'h0);
        expect_rd("R2 cfg", 12'h000, 32'h0004_0002);
        expect_rd("R1 pol w0", 12'h040, 32'hFFFF_FFFF);
        expect_rd("R11 pol w1 unused bits", 12'h044, 32'h0000_00FF);
        expect_rd("R1 trig w0", 12'h080, 32'h0);
        expect_rd("R1 dual w1", 12'h0C4, 32'h0);
        expect_rd("R1 mask w0", 12'h100, 32'h0);
        expect_rd("R1 pend w0", 12'h1C0, 32'h0);
        expect_rd("R1 route 39", 12'h49C, 32'h0);
        for (int c = 0; c < NC; c++) expect_rd("R1 lowest", 12'(12'h800 + 4 * c), 32'(NS));

        // table of single-source patterns on source 33
        for (int n = 0; n < 7; n++) begin
            src_in[TS] = VECS[n].init;
            idle(4);
            wr(12'h044, 32'(VECS[n].pol)  << 1);
            wr(12'h084, 32'(VECS[n].trig) << 1);
            wr(12'h0C4, 32'(VECS[n].dual) << 1);
            wr(12'h004, 32'(TS));
            for (int k = 0; k < 4; k++) begin
                src_in[TS] = VECS[n].seq[k];
                idle(4);
                rd(12'h1C4, v);
                check(VECS[n].trig ? (VECS[n].dual ? "R5 dual edge" : "R4 edge")
                                   : "R3 level", 32'(v[1]), 32'(VECS[n].exp[k]));
            end
        end
        src_in[TS] = 1'b0;
        wr(12'h044, 32'h0000_00FF);
        wr(12'h084, 32'h0);
        wr(12'h0C4, 32'h0);
        idle(4);

        // enable set / clear
        wr(12'h140, 32'h0000_00F0);
        expect_rd("R6 set", 12'h100, 32'h0000_00F0);
        wr(12'h140, 32'h0000_0003);
        expect_rd("R6 set keeps", 12'h100, 32'h0000_00F3);
        wr(12'h180, 32'h0000_0011);
        expect_rd("R6 clear", 12'h100, 32'h0000_00E2);
        wr(12'h180, 32'h0);
        expect_rd("R6 zero no effect", 12'h100, 32'h0000_00E2);
        wr(12'h142, 32'hFFFF_FFFF);
        expect_rd("R11 misaligned ignored", 12'h100, 32'h0000_00E2);
        wr(12'h144, 32'hFFFF_FFFF);
        expect_rd("R11 mask w1 unused bits", 12'h104, 32'h0000_00FF);
        wr(12'h180, 32'hFFFF_FFFF);
        wr(12'h184, 32'hFFFF_FFFF);
        expect_rd("R6 cleared", 12'h104, 32'h0);

        // wedge
        wr(12'h080, 32'h0000_002C);
        wr(12'h004, 32'h8000_0005);
        expect_rd("R7 wedge set", 12'h1C0, 32'h0000_0020);
        wr(12'h004, 32'h8000_0006);
        expect_rd("R7 wedge set on level", 12'h1C0, 32'h0000_0020);
        src_in[6] = 1'b1;
        idle(3);
        wr(12'h004, 32'h0000_0006);
        expect_rd("R7 wedge clear on level", 12'h1C0, 32'h0000_0060);
        src_in[6] = 1'b0;
        idle(3);
        wr(12'h004, 32'h8000_0000 | 32'(NS));
        expect_rd("R7 out of range w0", 12'h1C0, 32'h0000_0020);
        expect_rd("R7 out of range w1", 12'h1C4, 32'h0);
        wr(12'h004, 32'h0000_0005);
        expect_rd("R7 wedge clear", 12'h1C0, 32'h0);

        // routing, requests, lowest source
        wr(12'h140, 32'h0000_002C);
        wr(12'h414, 32'd2);
        wr(12'h004, 32'h8000_0005);
        check("R9 irq to cpu2", 32'(cpu_irq), 32'b100);
        expect_rd("R10 lowest cpu2", 12'h808, 32'd5);
        expect_rd("R10 lowest cpu0 none", 12'h800, 32'(NS));
        wr(12'h414, 32'd3);
        expect_rd("R8 bad route ignored", 12'h414, 32'd2);
        check("R8 irq after bad route", 32'(cpu_irq), 32'b100);
        wr(12'h004, 32'h8000_0003);
        check("R9 irq cpu0 and cpu2", 32'(cpu_irq), 32'b101);
        expect_rd("R10 lowest cpu0", 12'h800, 32'd3);
        wr(12'h408, 32'd2);
        wr(12'h004, 32'h8000_0002);
        expect_rd("R10 lowest cpu2 picks 2", 12'h808, 32'd2);
        wr(12'h40C, 32'd1);
        check("R8 moved source", 32'(cpu_irq), 32'b110);
        expect_rd("R8 cpu0 empty", 12'h800, 32'(NS));
        expect_rd("R10 lowest cpu1", 12'h804, 32'd3);
        wr(12'h180, 32'h0000_0024);
        check("R9 masked excluded", 32'(cpu_irq), 32'b010);
        expect_rd("R9 pending kept", 12'h1C0, 32'h0000_002C);
        wr(12'h144, 32'h0000_0080);
        src_in[39] = 1'b1;
        idle(3);
        check("R9 level source cpu0", 32'(cpu_irq), 32'b011);
        expect_rd("R10 lowest cpu0 is 39", 12'h800, 32'd39);
        src_in[39] = 1'b0;

        // exact latency of level and edge paths
        wr(12'h004, 32'h0000_0002);
        src_in[2] = 1'b1;
        idle(2);
        rd(12'h1C0, v);
        check("R4 not yet latched", 32'(v[2]), 32'd0);
        idle(1);
        rd(12'h1C0, v);
        check("R4 latched on third edge", 32'(v[2]), 32'd1);
        src_in[6] = 1'b1;
        idle(1);
        rd(12'h1C0, v);
        check("R3 not yet visible", 32'(v[6]), 32'd0);
        idle(1);
        rd(12'h1C0, v);
        check("R3 visible on second edge", 32'(v[6]), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule